// File: doc/BRIEF.md
# Scaled Timestamp Counter

This block keeps a free-running timestamp whose count is already expressed in a real time unit rather than in raw clock cycles. It runs from a 50 MHz core clock. A configuration word picks the unit. In nanosecond mode the count grows by 20 on every core cycle, so its resolution is 20 ns. In microsecond mode it grows by one every 50 cycles. In millisecond mode it grows by one every 50000 cycles. Any other unit code stops the count where it is.

Software reaches the block through a small register port with two word addresses. Address 0 holds the configuration word. The unit code sits in bits 7:0, and bit 8 is a clear control. Address 1 returns the count and cannot be written. To zero the timestamp, software writes the current unit code with bit 8 set and then writes it again with bit 8 clear. The unit therefore survives the clear.

A read samples the addressed register in a single cycle. The full count is therefore always taken from one instant, and a read never mixes bits from two different counts.

Top module: `tst_timer`

## Requirements
- R1: After reset the configuration word is 0 (nanosecond unit, clear bit low), the count is 0 and `rdata_o` is 0. Counting starts on the first clock edge after reset is released.
- R2: With unit code 0 and bit 8 low, the count grows by 20 (`NS_STEP`) on every core cycle.
- R3: With unit code 1 and bit 8 low, the count grows by 1 once every 50 (`US_DIV`) core cycles. After a clear, the first step lands exactly 50 cycles after bit 8 is dropped.
- R4: With unit code 2 and bit 8 low, the count grows by 1 once every 50000 (`MS_DIV`) core cycles.
- R5: While configuration bit 8 is high, the count is held at 0 and the cycle prescaler is cleared. The unit code in bits 7:0 is kept, so writing the same code with bit 8 low resumes counting from 0 in the same unit.
- R6: A unit code from 3 to 255 in bits 7:0 with bit 8 low freezes the count at its current value.
- R7: A write to address 0 stores bits 15:0 of `wdata_i` exactly as given, whether or not the unit code is valid. Bits 31:16 of the write are ignored, and a read of address 0 returns the stored word with bits 31:16 zero.
- R8: The count wraps modulo 2^`CNT_W`.
- R9: A write to address 1 (the count) changes neither the count nor the configuration word.
- R10: A read takes a copy of the addressed register on the clock edge where `rd_en_i` is high. The copy appears on `rdata_o` after that edge and stays there until the next read. The count is zero-extended to 32 bits.
- R11: A change of unit code without a clear applies from the next cycle. The count keeps its value, and the prescaler starts from 0 when the previous unit was nanoseconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 1 | Register select: 0 selects the configuration word, 1 selects the count |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data captured by the last read |

## Verification
Each unit code is started from a clear and then read after a chosen number of waiting cycles. The nanosecond runs use 0, 1 and 13 cycles and show the step size. The microsecond runs use 49, 50 and 173 cycles and show the exact prescaler boundary and the rounding down between steps. The millisecond runs use 20 and 50000 cycles. Codes 3 and 255 show that an invalid unit freezes the count instead of falling back to nanoseconds. A second instance with an 8-bit count receives the same writes, and its results show the wrap. Directed sequences then separate four behaviours that the unit runs cannot tell apart:
- a clear held high for many cycles;
- a unit change without a clear;
- a write to the read-only count;
- a read copy that must hold while the count keeps moving.

// File: rtl/tst_pkg.sv
package tst_pkg;
    localparam int CFG_W   = 16;
    localparam int BUS_W   = 32;
    localparam int SRC_W   = 8;
    localparam int CLR_BIT = 8;

    typedef enum logic [SRC_W-1:0] {
        UNIT_NS = 8'd0,
        UNIT_US = 8'd1,
        UNIT_MS = 8'd2
    } unit_e;

    typedef enum logic {
        REG_CFG = 1'b0,
        REG_CNT = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/tst_cfg_reg.sv
module tst_cfg_reg
    import tst_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [CFG_W-1:0] wdata_i,
    output logic [CFG_W-1:0] cfg_o,
    output logic [SRC_W-1:0] src_o,
    output logic             clear_o
);
    typedef struct packed {
        logic [CFG_W-1:0] cfg;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.cfg = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o   = st_q.cfg;
    assign src_o   = st_q.cfg[SRC_W-1:0];
    assign clear_o = st_q.cfg[CLR_BIT];
endmodule

// File: rtl/tst_prescale.sv
module tst_prescale
    import tst_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NS_STEP = 20,
    parameter int US_DIV  = 50,
    parameter int MS_DIV  = 50000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SRC_W-1:0] src_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] inc_o
);
    localparam int DIV_MAX = (MS_DIV > US_DIV) ? MS_DIV : US_DIV;
    localparam int PRE_W   = $clog2(DIV_MAX);
    localparam logic [PRE_W-1:0] US_LAST = PRE_W'(US_DIV - 1);
    localparam logic [PRE_W-1:0] MS_LAST = PRE_W'(MS_DIV - 1);
    localparam logic [CNT_W-1:0] NS_INC  = CNT_W'(NS_STEP);
    localparam logic [CNT_W-1:0] ONE_INC = CNT_W'(1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        inc_o = '0;
        if (clear_i) begin
            st_d.pre = '0;
        end else begin
            case (src_i)
                UNIT_NS: begin
                    st_d.pre = '0;
                    inc_o    = NS_INC;
                end
                UNIT_US: begin
                    if (st_q.pre >= US_LAST) begin
                        st_d.pre = '0;
                        inc_o    = ONE_INC;
                    end else begin
                        st_d.pre = st_q.pre + PRE_W'(1);
                    end
                end
                UNIT_MS: begin
                    if (st_q.pre >= MS_LAST) begin
                        st_d.pre = '0;
                        inc_o    = ONE_INC;
                    end else begin
                        st_d.pre = st_q.pre + PRE_W'(1);
                    end
                end
                default: begin
                    st_d.pre = st_q.pre;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tst_accum.sv
module tst_accum #(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] inc_i,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } acc_st_t;

    acc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.count = '0;
        end else begin
            st_d.count = st_q.count + inc_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;
endmodule

// File: rtl/tst_rd_port.sv
module tst_rd_port
    import tst_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rd_i,
    input  logic             sel_i,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [BUS_W-1:0] rdata_o
);
    typedef struct packed {
        logic [BUS_W-1:0] data;
    } rd_st_t;

    rd_st_t st_d, st_q;
    logic [BUS_W-1:0] cnt_ext;
    logic [BUS_W-1:0] cfg_ext;

    generate
        if (CNT_W < BUS_W) begin : g_pad
            assign cnt_ext = {{(BUS_W - CNT_W){1'b0}}, count_i};
        end else begin : g_trim
            assign cnt_ext = count_i[BUS_W-1:0];
        end
    endgenerate

    assign cfg_ext = {{(BUS_W - CFG_W){1'b0}}, cfg_i};

    always_comb begin
        st_d = st_q;
        if (rd_i) begin
            st_d.data = (sel_i == REG_CNT) ? cnt_ext : cfg_ext;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.data;
endmodule

// File: rtl/tst_timer.sv
module tst_timer
    import tst_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NS_STEP = 20,
    parameter int US_DIV  = 50,
    parameter int MS_DIV  = 50000
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wr_en_i,
    input  logic        rd_en_i,
    input  logic        addr_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rdata_o
);
    logic             cfg_wr;
    logic [CFG_W-1:0] cfg_word;
    logic [SRC_W-1:0] unit_src;
    logic             clr_hold;
    logic [CNT_W-1:0] step_amt;
    logic [CNT_W-1:0] count_val;
    logic             unused_wdata;

    assign cfg_wr       = wr_en_i && (addr_i == REG_CFG);
    assign unused_wdata = ^wdata_i[BUS_W-1:CFG_W];

    tst_cfg_reg i_cfg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (cfg_wr),
        .wdata_i (wdata_i[CFG_W-1:0]),
        .cfg_o   (cfg_word),
        .src_o   (unit_src),
        .clear_o (clr_hold)
    );

    tst_prescale #(
        .CNT_W   (CNT_W),
        .NS_STEP (NS_STEP),
        .US_DIV  (US_DIV),
        .MS_DIV  (MS_DIV)
    ) i_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .src_i   (unit_src),
        .clear_i (clr_hold),
        .inc_o   (step_amt)
    );

    tst_accum #(
        .CNT_W (CNT_W)
    ) i_acc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (clr_hold),
        .inc_i   (step_amt),
        .count_o (count_val)
    );

    tst_rd_port #(
        .CNT_W (CNT_W)
    ) i_rd (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rd_i    (rd_en_i),
        .sel_i   (addr_i),
        .cfg_i   (cfg_word),
        .count_i (count_val),
        .rdata_o (rdata_o)
    );
endmodule

// File: rtl/tst_timer_chk.sv
module tst_timer_chk
    import tst_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NS_STEP = 20
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_en_i,
    input logic             rd_en_i,
    input logic             addr_i,
    input logic [CFG_W-1:0] wdata_lo,
    input logic [31:0]      rdata_o,
    input logic [CFG_W-1:0] cfg,
    input logic [CNT_W-1:0] count
);
    p_ns_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg[SRC_W-1:0] == 8'd0 && !cfg[CLR_BIT])
        |=> (count == CNT_W'($past(count) + CNT_W'(NS_STEP))));

    p_us_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg[SRC_W-1:0] == 8'd1 && !cfg[CLR_BIT])
        |=> ((count == $past(count)) || (count == CNT_W'($past(count) + CNT_W'(1)))));

    p_clear_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg[CLR_BIT] |=> (count == '0));

    p_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg[SRC_W-1:0] > 8'd2 && !cfg[CLR_BIT]) |=> $stable(count));

    p_cfg_store_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 1'b0) |=> (cfg == $past(wdata_lo)));

    p_cnt_wr_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 1'b1) |=> $stable(cfg));

    p_rd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rdata_o));

    p_rd_count_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && addr_i == 1'b1) |=> (rdata_o[CNT_W-1:0] == $past(count)));
endmodule

bind tst_timer tst_timer_chk #(
    .CNT_W   (CNT_W),
    .NS_STEP (NS_STEP)
) i_tst_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .wdata_lo (wdata_i[tst_pkg::CFG_W-1:0]),
    .rdata_o  (rdata_o),
    .cfg      (cfg_word),
    .count    (count_val)
);

// File: tb/test_tst_timer.sv
module test_tst_timer;
    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        addr  = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] rdata8;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tst_timer i_tst_timer (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata)
    );

    tst_timer #(.CNT_W(8)) i_tst_timer_w8 (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata8)
    );

    typedef struct packed {
        logic [7:0]  src;
        logic [31:0] wait_n;
        logic [31:0] exp;
    } vec_t;

    localparam int N_VEC = 10;
    localparam vec_t VECS [N_VEC] = '{
        '{8'd0,   32'd0,     32'd0},
        '{8'd0,   32'd1,     32'd20},
        '{8'd0,   32'd13,    32'd260},
        '{8'd1,   32'd49,    32'd0},
        '{8'd1,   32'd50,    32'd1},
        '{8'd1,   32'd173,   32'd3},
        '{8'd2,   32'd20,    32'd0},
        '{8'd2,   32'd50000, 32'd1},
        '{8'd3,   32'd25,    32'd0},
        '{8'd255, 32'd25,    32'd0}
    };

    function automatic string tag_of(logic [7:0] s);
        case (s)
            8'd0:    return "R2";
            8'd1:    return "R3";
            8'd2:    return "R4";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // called at a negedge, returns at the next negedge
    task automatic bus_write(logic a, logic [31:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(logic a, output logic [31:0] d, output logic [31:0] d8);
        rd_en = 1'b1;
        addr  = a;
        @(negedge clk);
        rd_en = 1'b0;
        d  = rdata;
        d8 = rdata8;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v8, a, b;
        repeat (3) @(negedge clk);
        check("R1 rdata in reset", rdata, 32'd0);
        rst_n = 1'b1;
        bus_read(1'b1, v, v8);
        check("R1 count after reset", v, 32'd0);
        bus_read(1'b0, v, v8);
        check("R1 cfg after reset", v, 32'd0);

        // R2: difference over ten cycles from power-on state
        bus_read(1'b1, a, v8);
        repeat (9) @(negedge clk);
        bus_read(1'b1, b, v8);
        check("R2 ns delta", b - a, 32'd200);

        // vector table: clear, select unit, wait, read
        for (int i = 0; i < N_VEC; i++) begin
            bus_write(1'b0, 32'h100 | {24'd0, VECS[i].src});
            bus_write(1'b0, {24'd0, VECS[i].src});
            repeat (VECS[i].wait_n) @(negedge clk);
            bus_read(1'b1, v, v8);
            check(tag_of(VECS[i].src), v, VECS[i].exp);
            check("R8 wrap narrow count", v8, VECS[i].exp & 32'hFF);
        end

        // R5: clear held high keeps zero, unit retained
        bus_write(1'b0, 32'h101);
        repeat (30) @(negedge clk);
        bus_read(1'b1, v, v8);
        check("R5 held zero", v, 32'd0);
        bus_read(1'b0, v, v8);
        check("R5 cfg with clear", v, 32'h101);
        bus_write(1'b0, 32'h001);
        bus_read(1'b0, v, v8);
        check("R5 unit retained", v, 32'h001);

        // R11: switch ns -> us without clear
        bus_write(1'b0, 32'h100);
        bus_write(1'b0, 32'h000);
        repeat (10) @(negedge clk);
        bus_write(1'b0, 32'h001);
        repeat (60) @(negedge clk);
        bus_read(1'b1, v, v8);
        check("R11 unit switch", v, 32'd221);

        // R6 and R7: invalid unit freezes, cfg stores low 16 bits
        bus_write(1'b0, 32'h100);
        bus_write(1'b0, 32'h000);
        repeat (4) @(negedge clk);
        bus_write(1'b0, 32'hABCD_F203);
        repeat (20) @(negedge clk);
        bus_read(1'b1, v, v8);
        check("R6 frozen value", v, 32'd100);
        bus_read(1'b0, v, v8);
        check("R7 cfg readback", v, 32'h0000_F203);
        repeat (5) @(negedge clk);
        bus_read(1'b1, v, v8);
        check("R6 still frozen", v, 32'd100);

        // R9: write to count address is ignored
        bus_write(1'b0, 32'h100);
        bus_write(1'b0, 32'h000);
        bus_write(1'b1, 32'h1234_5678);
        repeat (3) @(negedge clk);
        bus_read(1'b1, v, v8);
        check("R9 count unaffected", v, 32'd80);
        bus_read(1'b0, v, v8);
        check("R9 cfg unaffected", v, 32'd0);

        // R10: read copy holds while count moves
        bus_read(1'b1, a, v8);
        repeat (5) @(negedge clk);
        check("R10 rdata held", rdata, a);
        bus_read(1'b1, b, v8);
        check("R10 new sample", b - a, 32'd120);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule